// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This combinational unit carries out the operation named by the second byte of a prefixed instruction on one 8-bit operand. It takes that second code byte, the operand and the current flag nibble. It returns three things: the new byte, a write-back enable and the new flag nibble. It also passes on the operand selector field, so that the surrounding datapath can fetch the operand and store the result. Operand fetch, the indirect memory access and cycle timing all belong to that datapath.

The top two bits of the code pick one of four groups. The first group holds eight shift and rotate kinds. The other three test, clear or set one bit. Bits 5..3 choose the shift kind, or the bit index for the three bit groups. A mode input makes the four rotate kinds behave like the single-byte accumulator rotates, which always clear the zero flag.

Top module: `prefix_bitops`

## Requirements
- R1: `reg_sel` equals code bits 2..0. The values 0..7 name the operands B, C, D, E, H, L, indirect (HL) and A, in that order.
- R2: The flag nibble is ordered Z (bit 3), N (bit 2), H (bit 1), C (bit 0). Code bits 7..6 pick the group: 00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set. Within the first group, bits 5..3 = 0..7 select RLC, RRC, RL, RR, SLA, SRA, SWAP, SRL.
- R3: RLC moves bit 7 into bit 0, and RRC moves bit 0 into bit 7. In both cases C receives the bit that moved.
- R4: RL shifts left and fills bit 0 from the incoming C. RR shifts right and fills bit 7 from the incoming C. C receives the bit shifted out.
- R5: SLA fills bit 0 with zero, SRA keeps bit 7, and SRL fills bit 7 with zero. C receives the bit shifted out.
- R6: SWAP exchanges the two nibbles and clears C.
- R7: With `acc_mode` low, every first-group operation clears N and H and sets Z exactly when the result is zero.
- R8: With `acc_mode` high, RLC, RRC, RL and RR clear Z, N and H, and their result and C are the same as in R3/R4. The other codes ignore `acc_mode`.
- R9: A bit test returns the operand unchanged with `wr_en` low. It sets Z when the indexed bit is 0, clears N, sets H and keeps C.
- R10: A bit clear forces the indexed bit to 0, keeps the other bits, and passes all four flags through unchanged.
- R11: A bit set forces the indexed bit to 1, keeps the other bits, and passes all four flags through unchanged.
- R12: `wr_en` is high for every code outside the bit-test group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 8 | Second code byte of the prefixed instruction |
| operand | input | 8 | Operand value fetched by the datapath |
| flags_in | input | 4 | Current flags, Z N H C from bit 3 down |
| acc_mode | input | 1 | Accumulator rotate variant (Z forced clear) |
| result | output | 8 | Result byte |
| wr_en | output | 1 | Result must be written back |
| flags_out | output | 4 | New flags, same layout as flags_in |
| reg_sel | output | 3 | Operand selector copied from code bits 2..0 |

## Verification
Two effects can act on the zero flag in the same evaluation: the accumulator mode and the result-zero detection. The bench provokes this by driving `acc_mode` at random across all 256 codes, and by forcing rotates whose result is zero (operands 0x00, and 0x80 or 0x01 with the carry clear). There, Z must read 0 under the mode and 1 without it, while non-rotate codes must keep the result-based Z whatever the mode is.

// File: rtl/prefix_bitops.sv
module prefix_bitops (
  input  logic [7:0] op_code,
  input  logic [7:0] operand,
  input  logic [3:0] flags_in,
  input  logic       acc_mode,
  output logic [7:0] result,
  output logic       wr_en,
  output logic [3:0] flags_out,
  output logic [2:0] reg_sel
);
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  localparam logic [1:0] GRP_SHIFT = 2'b00;
  localparam logic [1:0] GRP_TEST  = 2'b01;
  localparam logic [1:0] GRP_CLR   = 2'b10;

  logic [1:0] grp;
  logic [2:0] sub;
  logic       shout;
  logic [7:0] mask;

  assign grp     = op_code[7:6];
  assign sub     = op_code[5:3];
  assign reg_sel = op_code[2:0];
  assign mask    = 8'(1) << sub;

  always_comb begin
    result    = operand;
    wr_en     = 1'b1;
    flags_out = flags_in;
    shout     = 1'b0;
    case (grp)
      GRP_SHIFT: begin
        case (sub)
          3'd0: begin result = {operand[6:0], operand[7]};     shout = operand[7]; end
          3'd1: begin result = {operand[0], operand[7:1]};     shout = operand[0]; end
          3'd2: begin result = {operand[6:0], flags_in[FC]};   shout = operand[7]; end
          3'd3: begin result = {flags_in[FC], operand[7:1]};   shout = operand[0]; end
          3'd4: begin result = {operand[6:0], 1'b0};           shout = operand[7]; end
          3'd5: begin result = {operand[7], operand[7:1]};     shout = operand[0]; end
          3'd6: begin result = {operand[3:0], operand[7:4]};   shout = 1'b0;       end
          default: begin result = {1'b0, operand[7:1]};        shout = operand[0]; end
        endcase
        flags_out[FZ] = (result == 8'h00) && !(acc_mode && !sub[2]);
        flags_out[FN] = 1'b0;
        flags_out[FH] = 1'b0;
        flags_out[FC] = shout;
      end
      GRP_TEST: begin
        wr_en         = 1'b0;
        flags_out[FZ] = ~operand[sub];
        flags_out[FN] = 1'b0;
        flags_out[FH] = 1'b1;
      end
      GRP_CLR: result = operand & ~mask;
      default: result = operand | mask;
    endcase

    if (grp == GRP_SHIFT) begin
      // R7
      shift_nh_chk: assert (flags_out[FN:FH] == 2'b00);
      // R3
      if (sub == 3'd0 || sub == 3'd1 || sub == 3'd6)
        circ_pop_chk: assert ($countones(result) == $countones(operand));
      // R8
      if (acc_mode && sub < 3'd4)
        acc_z_chk: assert (!flags_out[FZ]);
      // R6
      if (sub == 3'd6)
        swap_c_chk: assert (!flags_out[FC]);
    end
    // R9
    if (grp == GRP_TEST)
      test_keep_chk: assert (!wr_en && result == operand && flags_out[FC] == flags_in[FC]);
    // R10
    if (grp == GRP_CLR)
      clr_bit_chk: assert (!result[sub] && flags_out == flags_in);
    // R11
    if (grp == 2'b11)
      set_bit_chk: assert (result[sub] && flags_out == flags_in);
    // R12
    if (grp != GRP_TEST)
      wr_on_chk: assert (wr_en);
  end
endmodule

// File: tb/prefix_bitops_tb.sv
module prefix_bitops_tb;
  logic       clk = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [3:0] flags_in = 4'h0;
  logic       acc_mode = 1'b0;
  logic [7:0] result;
  logic       wr_en;
  logic [3:0] flags_out;
  logic [2:0] reg_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prefix_bitops u_dut (
    .op_code(op_code), .operand(operand), .flags_in(flags_in),
    .acc_mode(acc_mode), .result(result), .wr_en(wr_en),
    .flags_out(flags_out), .reg_sel(reg_sel)
  );

  function automatic logic [12:0] model(input logic [7:0] op, input logic [7:0] v,
                                        input logic [3:0] f, input logic am);
    logic [7:0] r;
    logic [3:0] fo;
    logic w;
    logic c;
    int idx;
    idx = int'(op[5:3]);
    r = v; fo = f; w = 1'b1; c = 1'b0;
    case (op[7:6])
      2'b00: begin
        case (op[5:3])
          3'd0: begin r = (v << 1) | (v >> 7); c = v[7]; end
          3'd1: begin r = (v >> 1) | (v << 7); c = v[0]; end
          3'd2: begin r = (v << 1) | {7'd0, f[0]}; c = v[7]; end
          3'd3: begin r = (v >> 1) | {f[0], 7'd0}; c = v[0]; end
          3'd4: begin r = v << 1; c = v[7]; end
          3'd5: begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
          3'd6: begin r = (v << 4) | (v >> 4); c = 1'b0; end
          default: begin r = v >> 1; c = v[0]; end
        endcase
        fo = {(r == 0) && !(am && op[5:3] < 3'd4), 1'b0, 1'b0, c};
      end
      2'b01: begin w = 1'b0; fo = {~v[idx], 1'b0, 1'b1, f[0]}; end
      2'b10: r[idx] = 1'b0;
      default: r[idx] = 1'b1;
    endcase
    return {w, fo, r};
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic am);
    if (op[7:6] == 2'b01) return "R9";
    if (op[7:6] == 2'b10) return "R10";
    if (op[7:6] == 2'b11) return "R11";
    if (am && op[5:3] < 3'd4) return "R8";
    case (op[5:3])
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd6: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%02h opd=%02h f=%01h am=%0b act=%0h exp=%0h",
               req, op_code, operand, flags_in, acc_mode, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [7:0] v,
                       input logic [3:0] f, input logic am);
    logic [12:0] e;
    @(posedge clk);
    #1;
    op_code = op; operand = v; flags_in = f; acc_mode = am;
    e = model(op, v, f, am);
    @(negedge clk);
    check(tag_of(op, am), 32'(result), 32'(e[7:0]));
    if (op[7:6] == 2'b00 && !am)
      check("R7", 32'(flags_out), 32'(e[11:8]));
    else
      check(tag_of(op, am), 32'(flags_out), 32'(e[11:8]));
    if (op[7:6] == 2'b01) check("R9", 32'(wr_en), 32'(e[12]));
    else                  check("R12", 32'(wr_en), 32'(e[12]));
    check("R1", 32'(reg_sel), 32'(op[2:0]));
  endtask

  initial begin
    logic [7:0] corners [6];
    process::self().srandom(32'd1977);
    corners[0] = 8'h00; corners[1] = 8'hFF; corners[2] = 8'h80;
    corners[3] = 8'h01; corners[4] = 8'h0F; corners[5] = 8'hA5;
    #5;
    // R2 reset-time state: code 0x00 (RLC B) on zero operand gives Z only
    check("R2", 32'({wr_en, flags_out, result}), 32'({1'b1, 4'b1000, 8'h00}));
    // R8 directed: rotate of zero with mode set clears Z; SLA ignores mode
    apply(8'h00, 8'h00, 4'hF, 1'b1);
    apply(8'h17, 8'h80, 4'h0, 1'b1);
    apply(8'h27, 8'h80, 4'h0, 1'b1);
    // R4 carry feed-in directed
    apply(8'h10, 8'h00, 4'h1, 1'b0);
    apply(8'h18, 8'h00, 4'h1, 1'b0);
    // R5 SRA sign keep
    apply(8'h2F, 8'h81, 4'h0, 1'b0);
    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 6; k++)
        apply(8'(op), corners[k], 4'($urandom), 1'($urandom));
      for (int k = 0; k < 6; k++)
        apply(8'(op), 8'($urandom), 4'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule